// File: doc/BRIEF.md
# Strap latch and mode controller

This block serves the multi-function pins of a clock generator. For a fixed window after the power-up reset, the shared pins are held as inputs. On the last cycle of that window they are sampled once as configuration straps. After that, the pins are released to drive clock outputs.

The latched values set several things:

- Five frequency straps form the hardware half of the frequency index.
- A select strap picks the rate of the shared 24/48 MHz output.
- A mode strap sets the role of the combined power-down/reset pin.

In power-down mode that pin is a debounced, active-low power-down input. In reset mode it is an open-drain, active-low output. A watchdog pulls it low for a fixed number of reference cycles when the watchdog is not kicked in time.

A register-file bit chooses where the effective 6-bit frequency index comes from. When the bit is clear, the index comes from the latched straps. When it is set, the index is a software value. A global tristate field puts every clock output into high impedance. The floating-pin defaults are the reset values of the strap latches, so the index reads as the default until the capture happens.

Top module: `strap_mode_ctrl`

## Requirements
- R1: While reset is asserted and until the capture, the latched straps hold their floating defaults. With hardware selection the index therefore reads 6'b001010 (frequency straps, highest bit first, 0,1,0,1,0). In the same window `sel_24m` is 1, `pdrst_is_output` is 0, `strap_oe` is all zeros, and `pd_req` and `rst_drive_low` are 0.
- R2: The strap pins are held as inputs for HOLD_CYCLES rising edges after reset release. They are captured on edge HOLD_CYCLES, and `strap_oe` rises to all ones after that same edge.
- R3: After the capture, changes on `fs_pin`, `sel_pin` or `mode_pin` have no effect until the next reset.
- R4: With `sw_sel`=0, `freq_index` equals {1'b0, latched fs[4:0]}, with fs[4] as bit 4.
- R5: With `sw_sel`=1, `freq_index` equals `sw_index` in the same cycle.
- R6: `sel_24m` equals the latched select strap; 1 means 24 MHz and 0 means 48 MHz.
- R7: While `tristate_all` is 1, `out_hiz` is 1 and every bit of `strap_oe` is 0. Clearing `tristate_all` restores the drive.
- R8: In power-down mode (latched mode strap 1), `pdrst_pin` must stay low through the two-flop synchroniser and then for DEB_CYCLES further cycles before `pd_req` asserts. A one-cycle low glitch does not assert `pd_req`. A sustained high level releases `pd_req` in the same way.
- R9: In reset mode (latched mode strap 0), `pdrst_is_output` is 1 and `pd_req` stays 0 whatever level `pdrst_pin` has.
- R10: In reset mode, `rst_drive_low` rises WDT_CYCLES edges after the edge that sampled the last kick.
- R11: The low pulse lasts exactly PULSE_CYCLES cycles, and kicks during the pulse are ignored.
- R12: After the pulse ends the timeout restarts from zero. With no kick, the next pulse starts WDT_CYCLES edges after the previous one ended.
- R13: In power-down mode the watchdog never drives the pin, with or without kicks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-up reset, active low |
| fs_pin | input | FS_W (5) | Frequency strap levels on the shared pins |
| sel_pin | input | 1 | 24/48 select strap level |
| mode_pin | input | 1 | Pin-mode strap level |
| sw_sel | input | 1 | Index source: 0 hardware straps, 1 software |
| sw_index | input | FS_W+1 (6) | Software frequency index |
| tristate_all | input | 1 | Force all clock outputs to high impedance |
| wdt_kick | input | 1 | Watchdog kick, one cycle |
| pdrst_pin | input | 1 | Level sensed on the power-down/reset pin |
| freq_index | output | FS_W+1 (6) | Effective frequency index |
| sel_24m | output | 1 | Shared output rate: 1 = 24 MHz, 0 = 48 MHz |
| out_hiz | output | 1 | Global high-impedance request |
| pd_req | output | 1 | Debounced power-down request |
| rst_drive_low | output | 1 | Open-drain pull-down enable for the reset pin |
| pdrst_is_output | output | 1 | Power-down/reset pin acts as output |
| strap_oe | output | FS_W+2 (7) | Drive enables of the shared strap pins |

## Verification
The bench measures the capture edge exactly. A design that samples one edge early or late would show drive enables in the wrong cycle. The bench then changes the straps after capture, and a design that keeps sampling would move the index. It times the watchdog pulse start and length against a queue of expected pulses, including a kick inside the pulse and the automatic restart. An off-by-one counter, a kick that restarts the pulse, or a watchdog that stops after one pulse each leaves a mismatched or missing queue entry. It also sends a one-cycle glitch on the power-down pin and drives that pin low in reset mode. A missing debounce or a missing mode gate would then raise the power-down request.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_RUN   = 2'd1,
    WD_PULSE = 2'd2
  } wd_state_t;

  // Effective index: hardware straps padded with a zero MSB, or software value.
  function automatic logic [5:0] pick_index(input logic use_sw,
                                            input logic [5:0] sw_idx,
                                            input logic [4:0] hw_fs);
    return use_sw ? sw_idx : {1'b0, hw_fs};
  endfunction

  // True when a counter started at zero has seen lim cycles.
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == (lim - 32'd1);
  endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int HOLD_CYCLES = 16,
  parameter int FS_W        = 5,
  parameter logic [FS_W-1:0] FS_DEFAULT = 5'b01010,
  parameter logic SEL_DEFAULT  = 1'b1,
  parameter logic MODE_DEFAULT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FS_W-1:0] fs_pin,
  input  logic            sel_pin,
  input  logic            mode_pin,
  output logic [FS_W-1:0] fs_q,
  output logic            sel_q,
  output logic            mode_q,
  output logic            done
);
  import strap_pkg::*;

  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          capture_now;

  assign capture_now = !done && at_limit(32'(cnt), 32'(HOLD_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done   <= 1'b0;
      fs_q   <= FS_DEFAULT;
      sel_q  <= SEL_DEFAULT;
      mode_q <= MODE_DEFAULT;
    end else if (capture_now) begin
      done   <= 1'b1;
      fs_q   <= fs_pin;
      sel_q  <= sel_pin;
      mode_q <= mode_pin;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Once captured, the straps are frozen until the next reset.
  assert_capture_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(fs_q) && $stable(sel_q) && $stable(mode_q)));

endmodule

// File: rtl/pd_filter.sv
module pd_filter #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pin_in,
  output logic pd_req
);
  import strap_pkg::*;

  localparam int DW = $clog2(DEB_CYCLES + 1);

  logic          s1, s2;
  logic          lvl;
  logic [DW-1:0] cnt;
  logic          differs;
  logic          settle_hit;

  assign differs    = (s2 != lvl);
  assign settle_hit = differs && at_limit(32'(cnt), 32'(DEB_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b1;
      cnt <= '0;
    end else if (!enable) begin
      lvl <= 1'b1;
      cnt <= '0;
    end else if (settle_hit) begin
      lvl <= s2;
      cnt <= '0;
    end else if (differs) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  assign pd_req = enable & ~lvl;

  // The filtered level only falls after the synchronised input was low.
  assert_pd_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl) |-> ($past(s2) == 1'b0));

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int WDT_CYCLES   = 1431800,
  parameter int PULSE_CYCLES = 57272
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic kick,
  output logic pull_low
);
  import strap_pkg::*;

  localparam int TW = $clog2(WDT_CYCLES + 1);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  wd_state_t     st;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pcnt;
  logic          timeout_hit;
  logic          pulse_end;

  assign timeout_hit = (st == WD_RUN) && !kick && at_limit(32'(tcnt), 32'(WDT_CYCLES));
  assign pulse_end   = (st == WD_PULSE) && at_limit(32'(pcnt), 32'(PULSE_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= WD_OFF;
      tcnt <= '0;
      pcnt <= '0;
    end else begin
      case (st)
        WD_OFF: begin
          if (enable) begin
            st   <= WD_RUN;
            tcnt <= '0;
          end
        end
        WD_RUN: begin
          if (!enable) begin
            st <= WD_OFF;
          end else if (kick) begin
            tcnt <= '0;
          end else if (timeout_hit) begin
            st   <= WD_PULSE;
            pcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        WD_PULSE: begin
          if (!enable) begin
            st <= WD_OFF;
          end else if (pulse_end) begin
            st   <= WD_RUN;
            tcnt <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: st <= WD_OFF;
      endcase
    end
  end

  assign pull_low = (st == WD_PULSE);

  assert_pulse_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_low && enable && !pulse_end) |=> pull_low);

  assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_end && enable) |=> (st == WD_RUN && tcnt == '0));

  assert_no_pulse_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pull_low);

endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl #(
  parameter int HOLD_CYCLES  = 16,
  parameter int FS_W         = 5,
  parameter int DEB_CYCLES   = 4,
  parameter int WDT_CYCLES   = 1431800,
  parameter int PULSE_CYCLES = 57272,
  parameter logic [FS_W-1:0] FS_DEFAULT = 5'b01010,
  parameter int IDX_W = FS_W + 1,
  parameter int NPIN  = FS_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FS_W-1:0]  fs_pin,
  input  logic             sel_pin,
  input  logic             mode_pin,
  input  logic             sw_sel,
  input  logic [IDX_W-1:0] sw_index,
  input  logic             tristate_all,
  input  logic             wdt_kick,
  input  logic             pdrst_pin,
  output logic [IDX_W-1:0] freq_index,
  output logic             sel_24m,
  output logic             out_hiz,
  output logic             pd_req,
  output logic             rst_drive_low,
  output logic             pdrst_is_output,
  output logic [NPIN-1:0]  strap_oe
);
  import strap_pkg::*;

  logic [FS_W-1:0] fs_q;
  logic            sel_q;
  logic            mode_q;
  logic            done;
  logic            pd_mode_en;
  logic            rst_mode_en;
  logic            drive_ok;

  strap_capture #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .FS_W        (FS_W),
    .FS_DEFAULT  (FS_DEFAULT),
    .SEL_DEFAULT (1'b1),
    .MODE_DEFAULT(1'b1)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs_pin  (fs_pin),
    .sel_pin (sel_pin),
    .mode_pin(mode_pin),
    .fs_q    (fs_q),
    .sel_q   (sel_q),
    .mode_q  (mode_q),
    .done    (done)
  );

  assign pd_mode_en  = done &  mode_q;
  assign rst_mode_en = done & ~mode_q;
  assign drive_ok    = done & ~tristate_all;

  pd_filter #(.DEB_CYCLES(DEB_CYCLES)) u_pd (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(pd_mode_en),
    .pin_in(pdrst_pin),
    .pd_req(pd_req)
  );

  wdt_pulse #(.WDT_CYCLES(WDT_CYCLES), .PULSE_CYCLES(PULSE_CYCLES)) u_wdt (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (rst_mode_en),
    .kick    (wdt_kick),
    .pull_low(rst_drive_low)
  );

  if (FS_W == 5) begin : g_idx_fn
    assign freq_index = pick_index(sw_sel, sw_index, fs_q);
  end else begin : g_idx_gen
    assign freq_index = sw_sel ? sw_index : {1'b0, fs_q};
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_oe
    assign strap_oe[i] = drive_ok;
  end

  assign sel_24m         = sel_q;
  assign out_hiz         = tristate_all;
  assign pdrst_is_output = rst_mode_en;

  // The shared pin is never both a power-down input and a driven reset.
  assert_pd_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> !rst_drive_low);

  // The watchdog pulse only appears once the pin has become an output.
  assert_pulse_needs_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_drive_low |-> pdrst_is_output);

endmodule

// File: tb/sim_strap_mode_ctrl.sv
module sim_strap_mode_ctrl;
  localparam int HOLD = 8;
  localparam int WDT  = 40;
  localparam int PUL  = 20;
  localparam int DEB  = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] fs_pin;
  logic       sel_pin, mode_pin, sw_sel, tristate_all, wdt_kick, pdrst_pin;
  logic [5:0] sw_index;
  logic [5:0] freq_index;
  logic       sel_24m, out_hiz, pd_req, rst_drive_low, pdrst_is_output;
  logic [6:0] strap_oe;

  always #2 clk = ~clk;

  strap_mode_ctrl #(
    .HOLD_CYCLES(HOLD), .DEB_CYCLES(DEB), .WDT_CYCLES(WDT), .PULSE_CYCLES(PUL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .fs_pin(fs_pin), .sel_pin(sel_pin), .mode_pin(mode_pin),
    .sw_sel(sw_sel), .sw_index(sw_index), .tristate_all(tristate_all),
    .wdt_kick(wdt_kick), .pdrst_pin(pdrst_pin), .freq_index(freq_index),
    .sel_24m(sel_24m), .out_hiz(out_hiz), .pd_req(pd_req),
    .rst_drive_low(rst_drive_low), .pdrst_is_output(pdrst_is_output),
    .strap_oe(strap_oe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    int    start;
    int    len;
    string tag;
  } pulse_t;
  pulse_t exp_q[$];
  pulse_t got_e;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic kick_once(output int edge_no);
    wdt_kick = 1'b1;
    edge_no  = cyc + 1;
    @(negedge clk);
    wdt_kick = 1'b0;
  endtask

  // Monitor: measures each reset pulse and compares it with the scoreboard.
  bit in_p = 0;
  int p_start = 0;
  int p_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_drive_low) begin
        if (!in_p) begin
          in_p    = 1;
          p_start = cyc;
          p_len   = 0;
        end
        p_len++;
      end else if (in_p) begin
        in_p = 0;
        if (exp_q.size() == 0) begin
          n_chk++;
          n_fail++;
          $display("FAIL R13 unexpected pulse actual=start %0d expected=none", p_start);
        end else begin
          got_e = exp_q.pop_front();
          check({got_e.tag, " pulse start"}, p_start, got_e.start);
          check({got_e.tag, " pulse length"}, p_len, got_e.len);
        end
      end
    end else begin
      in_p = 0;
    end
  end

  task automatic summary();
    while (exp_q.size() != 0) begin
      got_e = exp_q.pop_front();
      n_chk++;
      n_fail++;
      $display("FAIL %s pulse missing actual=none expected=start %0d", got_e.tag, got_e.start);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int e;
    rst_n = 0; fs_pin = 5'b10110; sel_pin = 0; mode_pin = 1;
    sw_sel = 0; sw_index = '0; tristate_all = 0; wdt_kick = 0; pdrst_pin = 1;
    repeat (3) @(negedge clk);
    // R1: defaults before capture
    check("R1 index default", freq_index, 6'h0A);
    check("R1 sel default", sel_24m, 1);
    check("R1 oe off", strap_oe, 0);
    check("R1 pin role", pdrst_is_output, 0);
    check("R1 no pd", pd_req, 0);
    rst_n = 1;
    check("R1 rst pin idle", rst_drive_low, 0);
    repeat (HOLD - 1) @(posedge clk);
    @(negedge clk);
    check("R2 still input", strap_oe, 0);
    check("R1 index held", freq_index, 6'h0A);
    @(posedge clk); @(negedge clk);
    check("R2 drive on", strap_oe, 7'h7F);
    check("R4 hw index", freq_index, 6'h16);
    check("R6 48MHz sel", sel_24m, 0);
    check("R8 pd role input", pdrst_is_output, 0);
    fs_pin = 5'b00001; sel_pin = 1; mode_pin = 0;
    repeat (3) @(negedge clk);
    check("R3 index frozen", freq_index, 6'h16);
    check("R3 sel frozen", sel_24m, 0);
    check("R3 mode frozen", pdrst_is_output, 0);
    sw_sel = 1; sw_index = 6'h2B;
    @(negedge clk);
    check("R5 sw index", freq_index, 6'h2B);
    sw_index = 6'h3F;
    @(negedge clk);
    check("R5 sw index top", freq_index, 6'h3F);
    sw_sel = 0;
    @(negedge clk);
    check("R4 back to hw", freq_index, 6'h16);
    tristate_all = 1;
    @(negedge clk);
    check("R7 hiz flag", out_hiz, 1);
    check("R7 oe forced off", strap_oe, 0);
    tristate_all = 0;
    @(negedge clk);
    check("R7 hiz cleared", out_hiz, 0);
    check("R7 oe restored", strap_oe, 7'h7F);
    // R8: glitch, sustained low, release
    pdrst_pin = 0; @(negedge clk); pdrst_pin = 1;
    repeat (12) @(negedge clk);
    check("R8 glitch ignored", pd_req, 0);
    pdrst_pin = 0;
    repeat (12) @(negedge clk);
    check("R8 pd asserted", pd_req, 1);
    pdrst_pin = 1;
    repeat (12) @(negedge clk);
    check("R8 pd released", pd_req, 0);
    // R13: no watchdog activity in power-down mode
    kick_once(e);
    repeat (3 * WDT) @(negedge clk);
    check("R13 no pulse in pd mode", rst_drive_low, 0);

    // Second power-up in reset mode
    rst_n = 0; fs_pin = 5'b11111; sel_pin = 1; mode_pin = 0; pdrst_pin = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
    check("R2 drive on again", strap_oe, 7'h7F);
    check("R9 pin is output", pdrst_is_output, 1);
    check("R4 hw index all ones", freq_index, 6'h1F);
    check("R6 24MHz sel", sel_24m, 1);
    pdrst_pin = 0;
    repeat (12) @(negedge clk);
    check("R9 pd ignored", pd_req, 0);
    pdrst_pin = 1;
    for (int k = 0; k < 4; k++) begin
      kick_once(e);
      repeat (WDT / 2) @(negedge clk);
    end
    check("R10 kicks hold off pulse", rst_drive_low, 0);
    kick_once(e);
    exp_q.push_back('{start: e + WDT, len: PUL, tag: "R10 R11"});
    exp_q.push_back('{start: e + 2 * WDT + PUL, len: PUL, tag: "R12"});
    while (cyc < e + WDT + 5) @(negedge clk);
    check("R11 pulse active", rst_drive_low, 1);
    begin
      int ign;
      kick_once(ign);  // R11: ignored during the pulse
    end
    while (cyc < e + 2 * WDT + 2 * PUL + 3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule